// File: doc/BRIEF.md
# Multi-cycle 16-bit load/store sequencer

This block is the control sequencer and datapath of a small multi-cycle processor with a 16-bit word. It fetches one fixed-length instruction at a time from a word-addressed instruction memory. It splits the instruction into fields that keep the same position and meaning for every opcode. It then steps the instruction through up to five numbered phases: fetch, decode, execute, memory and writeback. Register-to-register operations never reach data memory. Only loads and stores drive the data memory port, and every access is a whole 16-bit word.

Each instruction uses only the phases it needs. A store ends once its memory write has happened. A load goes on to a fifth phase that writes the fetched word into its destination register. ALU operations skip the memory phase. A zero-test branch finishes in execute. An unknown opcode returns to fetch straight after decode.

Both memories answer combinationally on the address the block presents. The block drives every memory-side output from a register.

Top module: `mc16_core`

## Requirements
- R1: While the synchronous active-high reset is asserted, and in the first cycle after it is released, the block shows instruction address 0 and holds the data write strobe low.
- R2: An instruction is decoded from these fields: opcode in bits 15:12, destination register in 11:9, first source register in 8:6, second source register in 5:3, 6-bit immediate in 5:0 and 3-bit immediate in 2:0. The opcodes are ADD=0, SUB=1, AND=2, OR=3, ADDI=4, LD=8, ST=9 and BZ=12. ADD, SUB, AND and OR combine the two source registers. ADDI adds the sign-extended 6-bit immediate to the first source.
- R3: Every instruction starts with a fetch phase followed by a decode phase.
- R4: During fetch the instruction address equals the program counter, and the program counter then advances by one.
- R5: A store writes the value of the second source register to address (first source + sign-extended bits 2:0). A load reads from address (first source + sign-extended bits 5:0).
- R6: The data write strobe is high for exactly one cycle per store, in that store's memory phase, and never at any other time.
- R7: A store takes four cycles (fetch, decode, execute, memory) and has no writeback phase.
- R8: A load takes five cycles and writes the data memory word into its destination register in the fifth.
- R9: ADD, SUB, AND, OR and ADDI take four cycles (fetch, decode, execute, writeback) and never touch data memory.
- R10: BZ takes three cycles. When its first source register is zero, the next fetch address is its own address + 1 + the sign-extended bits 5:0. Otherwise it is its own address + 1.
- R11: Register 0 always reads as zero, and any write to it is discarded.
- R12: An opcode not listed in R2 takes two cycles (fetch, decode) and changes no register, no memory word and no program counter value beyond the fetch increment.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | ADDR_W | Word address of the instruction to fetch (program counter) |
| imem_rdata | input | 16 | Instruction word at imem_addr, same cycle |
| dmem_addr | output | ADDR_W | Registered data word address for loads and stores |
| dmem_wdata | output | DATA_W | Registered store data |
| dmem_we | output | 1 | Registered write strobe, one cycle per store |
| dmem_rdata | input | DATA_W | Data word at dmem_addr, same cycle |

## Verification
A short program is run with each arithmetic opcode on a positive and a negative operand. This exposes operand swaps and a wrong ALU function. Stores use zero, positive and negative 3-bit offsets, and loads use a negative 6-bit offset, so a wrong immediate width or a missing sign extension lands on a different word. The program writes into register 0 and then stores it, places an unknown opcode whose fields look like an ADDI, and runs a taken and a not-taken zero branch with stores in the skipped slots. Comparing the fetch address on every cycle against a behavioural model pins the phase count of each instruction class. This separates a store with a stray writeback phase from a correct one.

// File: rtl/mc16_pkg.sv
package mc16_pkg;

  localparam int INSTR_W = 16;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_AND  = 4'd2,
    OP_OR   = 4'd3,
    OP_ADDI = 4'd4,
    OP_LD   = 4'd8,
    OP_ST   = 4'd9,
    OP_BZ   = 4'd12
  } opcode_e;

  typedef enum logic [2:0] {
    PH_FETCH  = 3'd0,
    PH_DECODE = 3'd1,
    PH_EXEC   = 3'd2,
    PH_MEM    = 3'd3,
    PH_WB     = 3'd4
  } phase_e;

  typedef enum logic [1:0] {
    ALU_ADD,
    ALU_SUB,
    ALU_AND,
    ALU_OR
  } alu_fn_e;

  // fixed field layout: positions never depend on the opcode
  typedef struct packed {
    logic [3:0] opc;
    logic [2:0] rd;
    logic [2:0] rs1;
    logic [5:0] low;
  } instr_t;

  function automatic logic opc_known(input logic [3:0] opc);
    case (opc)
      OP_ADD, OP_SUB, OP_AND, OP_OR, OP_ADDI, OP_LD, OP_ST, OP_BZ: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/mc16_alu.sv
module mc16_alu
  import mc16_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  alu_fn_e           fn,
  input  logic [DATA_W-1:0] x,
  input  logic [DATA_W-1:0] y,
  output logic [DATA_W-1:0] res
);

  always_comb begin
    case (fn)
      ALU_SUB: res = x - y;
      ALU_AND: res = x & y;
      ALU_OR:  res = x | y;
      default: res = x + y;
    endcase
  end

endmodule

// File: rtl/mc16_regfile.sv
module mc16_regfile #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8,
  parameter int NPORTS = 2,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic                     clk,
  input  logic                     wr_en,
  input  logic [IDX_W-1:0]         wr_idx,
  input  logic [DATA_W-1:0]        wr_data,
  input  logic [NPORTS*IDX_W-1:0]  rd_idx,
  output logic [NPORTS*DATA_W-1:0] rd_data
);

  logic [DATA_W-1:0] cells [DEPTH];

  // entry 0 is never written, so it needs no storage semantics of its own
  always_ff @(posedge clk) begin
    if (wr_en && wr_idx != '0) cells[wr_idx] <= wr_data;
  end

  for (genvar p = 0; p < NPORTS; p++) begin : g_rport
    logic [IDX_W-1:0] idx;
    assign idx = rd_idx[p*IDX_W +: IDX_W];
    assign rd_data[p*DATA_W +: DATA_W] = (idx == '0) ? '0 : cells[idx];
  end

endmodule

// File: rtl/mc16_ctrl.sv
module mc16_ctrl
  import mc16_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [3:0] opc,
  output phase_e     phase
);

  phase_e nxt;

  always_comb begin
    nxt = PH_FETCH;
    case (phase)
      PH_FETCH:  nxt = PH_DECODE;
      PH_DECODE: nxt = opc_known(opc) ? PH_EXEC : PH_FETCH;
      PH_EXEC: begin
        if (opc == OP_LD || opc == OP_ST) nxt = PH_MEM;
        else if (opc == OP_BZ)            nxt = PH_FETCH;
        else                              nxt = PH_WB;
      end
      PH_MEM:    nxt = (opc == OP_LD) ? PH_WB : PH_FETCH;
      default:   nxt = PH_FETCH;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) phase <= PH_FETCH;
    else     phase <= nxt;
  end

  // R3
  fetch_then_decode_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_FETCH) |=> (phase == PH_DECODE));

  // R7
  store_no_wb_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_MEM && opc == OP_ST) |=> (phase == PH_FETCH));

  // R8
  load_has_wb_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_MEM && opc == OP_LD) |=> (phase == PH_WB));

endmodule

// File: rtl/mc16_core.sv
module mc16_core
  import mc16_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 16,
  parameter int REGS   = 8
) (
  input  logic               clk,
  input  logic               rst,
  output logic [ADDR_W-1:0]  imem_addr,
  input  logic [INSTR_W-1:0] imem_rdata,
  output logic [ADDR_W-1:0]  dmem_addr,
  output logic [DATA_W-1:0]  dmem_wdata,
  output logic               dmem_we,
  input  logic [DATA_W-1:0]  dmem_rdata
);

  localparam int IDX_W = $clog2(REGS);

  phase_e            phase;
  instr_t            ir_q;
  logic [ADDR_W-1:0] pc_q;
  logic [DATA_W-1:0] opa_q, opb_q, imm_q, alu_q, mdr_q;
  logic [ADDR_W-1:0] daddr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              we_q;

  logic [2*IDX_W-1:0]  rf_idx;
  logic [2*DATA_W-1:0] rf_rd;
  logic                rf_we;
  logic [DATA_W-1:0]   rf_wdata;

  alu_fn_e           fn;
  logic [DATA_W-1:0] alu_y, alu_res;
  logic [DATA_W-1:0] sx6, sx3;
  logic              uses_imm, is_mem;

  assign sx6 = {{(DATA_W-6){ir_q.low[5]}}, ir_q.low};
  assign sx3 = {{(DATA_W-3){ir_q.low[2]}}, ir_q.low[2:0]};

  // read port 0 serves the first source, port 1 the second source
  assign rf_idx = {IDX_W'(ir_q.low[5:3]), IDX_W'(ir_q.rs1)};

  mc16_ctrl u_ctrl (
    .clk   (clk),
    .rst   (rst),
    .opc   (ir_q.opc),
    .phase (phase)
  );

  mc16_regfile #(
    .DATA_W (DATA_W),
    .DEPTH  (REGS),
    .NPORTS (2)
  ) u_rf (
    .clk     (clk),
    .wr_en   (rf_we),
    .wr_idx  (IDX_W'(ir_q.rd)),
    .wr_data (rf_wdata),
    .rd_idx  (rf_idx),
    .rd_data (rf_rd)
  );

  always_comb begin
    case (ir_q.opc)
      OP_SUB:  fn = ALU_SUB;
      OP_AND:  fn = ALU_AND;
      OP_OR:   fn = ALU_OR;
      default: fn = ALU_ADD;
    endcase
  end

  assign is_mem   = (ir_q.opc == OP_LD) || (ir_q.opc == OP_ST);
  assign uses_imm = is_mem || (ir_q.opc == OP_ADDI);
  assign alu_y    = uses_imm ? imm_q : opb_q;

  mc16_alu #(.DATA_W(DATA_W)) u_alu (
    .fn  (fn),
    .x   (opa_q),
    .y   (alu_y),
    .res (alu_res)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q    <= '0;
      ir_q    <= '0;
      opa_q   <= '0;
      opb_q   <= '0;
      imm_q   <= '0;
      alu_q   <= '0;
      mdr_q   <= '0;
      daddr_q <= '0;
      wdata_q <= '0;
      we_q    <= 1'b0;
    end else begin
      we_q <= 1'b0;
      case (phase)
        PH_FETCH: begin
          ir_q <= imem_rdata;
          pc_q <= pc_q + ADDR_W'(1);
        end
        PH_DECODE: begin
          opa_q <= rf_rd[0 +: DATA_W];
          opb_q <= rf_rd[DATA_W +: DATA_W];
          imm_q <= (ir_q.opc == OP_ST) ? sx3 : sx6;
        end
        PH_EXEC: begin
          alu_q <= alu_res;
          if (is_mem) daddr_q <= ADDR_W'(alu_res);
          if (ir_q.opc == OP_ST) begin
            wdata_q <= opb_q;
            we_q    <= 1'b1;
          end
          if (ir_q.opc == OP_BZ && opa_q == '0) pc_q <= pc_q + ADDR_W'(imm_q);
        end
        PH_MEM: begin
          if (ir_q.opc == OP_LD) mdr_q <= dmem_rdata;
        end
        default: ;
      endcase
    end
  end

  assign rf_we    = (phase == PH_WB);
  assign rf_wdata = (ir_q.opc == OP_LD) ? mdr_q : alu_q;

  assign imem_addr  = pc_q;
  assign dmem_addr  = daddr_q;
  assign dmem_wdata = wdata_q;
  assign dmem_we    = we_q;

  // R4
  pc_step_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_FETCH) |=> (pc_q == $past(pc_q) + ADDR_W'(1)));

  // R6
  we_in_store_mem_chk: assert property (@(posedge clk) disable iff (rst)
    dmem_we |-> (phase == PH_MEM && ir_q.opc == OP_ST));

  // R12
  unknown_skip_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_DECODE && !opc_known(ir_q.opc)) |=>
      (phase == PH_FETCH && pc_q == $past(pc_q) && !dmem_we));

  // R9
  alu_no_mem_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_WB && !is_mem) |-> !dmem_we);

endmodule

// File: tb/tb_mc16_core.sv
module tb_mc16_core;

  localparam int CLK_PERIOD = 10;
  localparam int RUN_CYCLES = 130;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] imem_addr, imem_rdata, dmem_addr, dmem_wdata, dmem_rdata;
  logic        dmem_we;

  logic [15:0] imem [64];
  logic [15:0] dmem [64];

  logic [15:0] m_reg [8];
  logic [15:0] m_mem [64];
  logic [15:0] m_pc;

  logic [15:0] q_ia [$];
  logic [15:0] q_ad [$];
  logic [15:0] q_wd [$];
  bit          q_we [$];
  string       q_tag [$];

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mc16_core dut (
    .clk        (clk),
    .rst        (rst),
    .imem_addr  (imem_addr),
    .imem_rdata (imem_rdata),
    .dmem_addr  (dmem_addr),
    .dmem_wdata (dmem_wdata),
    .dmem_we    (dmem_we),
    .dmem_rdata (dmem_rdata)
  );

  assign imem_rdata = imem[imem_addr[5:0]];
  assign dmem_rdata = dmem[dmem_addr[5:0]];

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 64; i++) dmem[i] <= 16'hA000 + 16'(i);
    end else if (dmem_we) begin
      dmem[dmem_addr[5:0]] <= dmem_wdata;
    end
  end

  function automatic logic [15:0] enc(input int op, input int rd, input int rs1, input int low);
    logic [31:0] o, d, s, l;
    o = op; d = rd; s = rs1; l = low;
    return {o[3:0], d[2:0], s[2:0], l[5:0]};
  endfunction

  task automatic chk16(input logic [15:0] act, input logic [15:0] exp,
                       input string tag, input string what);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic push(input logic [15:0] ia, input bit we, input logic [15:0] ad,
                      input logic [15:0] wd, input string tag);
    q_ia.push_back(ia);
    q_we.push_back(we);
    q_ad.push_back(ad);
    q_wd.push_back(wd);
    q_tag.push_back(tag);
  endtask

  function automatic logic [15:0] rv(input int idx);
    return (idx == 0) ? 16'h0000 : m_reg[idx];
  endfunction

  // behavioural model: one whole instruction per call, expanded into per-cycle expectations
  task automatic model_step();
    logic [15:0] p, ins, va, vb, s6, s3, res, ea;
    int op, rd, rs1, rs2;
    p   = m_pc;
    ins = imem[p[5:0]];
    op  = int'(ins[15:12]);
    rd  = int'(ins[11:9]);
    rs1 = int'(ins[8:6]);
    rs2 = int'(ins[5:3]);
    va  = rv(rs1);
    vb  = rv(rs2);
    s6  = {{10{ins[5]}}, ins[5:0]};
    s3  = {{13{ins[2]}}, ins[2:0]};
    push(p, 1'b0, 16'h0, 16'h0, "R4");
    if (op <= 4) begin
      case (op)
        0: res = va + vb;
        1: res = va - vb;
        2: res = va & vb;
        3: res = va | vb;
        default: res = va + s6;
      endcase
      push(p + 16'd1, 1'b0, 16'h0, 16'h0, "R3");
      push(p + 16'd1, 1'b0, 16'h0, 16'h0, "R9");
      push(p + 16'd1, 1'b0, 16'h0, 16'h0, "R9");
      if (rd != 0) m_reg[rd] = res;
      m_pc = p + 16'd1;
    end else if (op == 8) begin
      ea = va + s6;
      push(p + 16'd1, 1'b0, 16'h0, 16'h0, "R3");
      push(p + 16'd1, 1'b0, 16'h0, 16'h0, "R8");
      push(p + 16'd1, 1'b0, 16'h0, 16'h0, "R8");
      push(p + 16'd1, 1'b0, 16'h0, 16'h0, "R8");
      if (rd != 0) m_reg[rd] = m_mem[ea[5:0]];
      m_pc = p + 16'd1;
    end else if (op == 9) begin
      ea = va + s3;
      push(p + 16'd1, 1'b0, 16'h0, 16'h0, "R3");
      push(p + 16'd1, 1'b0, 16'h0, 16'h0, "R7");
      push(p + 16'd1, 1'b1, ea, vb, "R7");
      m_mem[ea[5:0]] = vb;
      m_pc = p + 16'd1;
    end else if (op == 12) begin
      push(p + 16'd1, 1'b0, 16'h0, 16'h0, "R3");
      push(p + 16'd1, 1'b0, 16'h0, 16'h0, "R10");
      m_pc = (va == 16'h0) ? p + 16'd1 + s6 : p + 16'd1;
    end else begin
      push(p + 16'd1, 1'b0, 16'h0, 16'h0, "R12");
      m_pc = p + 16'd1;
    end
  endtask

  task automatic compare_cycle();
    logic [15:0] ia, ad, wd;
    bit we;
    string tg;
    if (q_ia.size() == 0) model_step();
    ia = q_ia.pop_front();
    we = q_we.pop_front();
    ad = q_ad.pop_front();
    wd = q_wd.pop_front();
    tg = q_tag.pop_front();
    chk16(imem_addr, ia, tg, "imem_addr");
    chk16({15'h0, dmem_we}, {15'h0, we}, "R6", "dmem_we");
    if (we) begin
      chk16(dmem_addr, ad, "R5", "dmem_addr");
      chk16(dmem_wdata, wd, "R5", "dmem_wdata");
    end
  endtask

  task automatic print_summary();
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) begin
      imem[i]  = 16'hF000;
      m_mem[i] = 16'hA000 + 16'(i);
    end
    for (int i = 0; i < 8; i++) m_reg[i] = 16'h0;
    m_pc = 16'h0;

    imem[0]  = enc(4, 1, 0, 10);               // ADDI r1 = 10
    imem[1]  = enc(4, 2, 0, -3);               // ADDI r2 = -3
    imem[2]  = enc(0, 3, 1, 2 << 3);           // ADD r3
    imem[3]  = enc(1, 4, 1, 2 << 3);           // SUB r4
    imem[4]  = enc(2, 5, 1, 2 << 3);           // AND r5
    imem[5]  = enc(3, 6, 1, 2 << 3);           // OR r6
    imem[6]  = enc(9, 0, 1, (3 << 3) | 0);     // ST r3 -> [r1+0]
    imem[7]  = enc(9, 0, 1, (4 << 3) | 4);     // ST r4 -> [r1-4]
    imem[8]  = enc(9, 0, 1, (5 << 3) | 3);     // ST r5 -> [r1+3]
    imem[9]  = enc(8, 7, 1, 0);                // LD r7 <- [r1]
    imem[10] = enc(9, 0, 0, (7 << 3) | 1);     // ST r7 -> [1]
    imem[11] = enc(4, 0, 0, 5);                // ADDI r0 (discarded)
    imem[12] = enc(9, 0, 0, (0 << 3) | 2);     // ST r0 -> [2]
    imem[13] = enc(8, 0, 1, 0);                // LD r0 (discarded)
    imem[14] = enc(9, 0, 0, (0 << 3) | 3);     // ST r0 -> [3]
    imem[15] = 16'h5245;                       // unknown opcode shaped like ADDI r1
    imem[16] = enc(12, 0, 0, 2);               // BZ r0 taken -> 19
    imem[17] = enc(9, 0, 0, (1 << 3) | 0);     // skipped
    imem[18] = enc(9, 0, 0, (1 << 3) | 0);     // skipped
    imem[19] = enc(12, 0, 1, 5);               // BZ r1 not taken
    imem[20] = enc(9, 0, 1, (6 << 3) | 7);     // ST r6 -> [r1-1]
    imem[21] = enc(8, 3, 1, -4);               // LD r3 <- [r1-4]
    imem[22] = enc(9, 0, 1, (3 << 3) | 1);     // ST r3 -> [r1+1]
    imem[23] = enc(12, 0, 0, -1);              // BZ r0 -> self

    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk16(imem_addr, 16'h0, "R1", "imem_addr in reset");
    chk16({15'h0, dmem_we}, 16'h0, "R1", "dmem_we in reset");
    rst = 1'b0;
    #1;
    chk16(imem_addr, 16'h0, "R1", "imem_addr after reset");
    compare_cycle();
    for (int c = 1; c < RUN_CYCLES; c++) begin
      @(negedge clk);
      compare_cycle();
    end
    @(negedge clk);

    for (int i = 0; i < 64; i++) chk16(dmem[i], m_mem[i], "R2", "dmem word");
    chk16(dmem[0],  m_mem[0],  "R10", "skipped store slot");
    chk16(dmem[1],  m_mem[1],  "R8",  "stored load result");
    chk16(dmem[2],  m_mem[2],  "R11", "r0 after ADDI");
    chk16(dmem[3],  m_mem[3],  "R11", "r0 after LD");
    chk16(dmem[6],  m_mem[6],  "R5",  "negative store offset");
    chk16(dmem[11], m_mem[11], "R8",  "negative load offset");
    chk16(dmem[13], m_mem[13], "R7",  "store with offset 3");
    chk16(dmem[9],  m_mem[9],  "R12", "store after unknown opcode");

    done = 1'b1;
    print_summary();
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL R3 watchdog: actual timeout expected completion");
      print_summary();
      $finish;
    end
  end

endmodule